// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block holds sixteen 48-bit event counters behind a small synchronous register bus. Each counter has an 8-bit event code. The code picks one line out of a 64-bit vector of single-cycle event pulses. A counter adds one on every clock in which its chosen line is high, its own enable bit is set and the global enable is set. Software can load and read any counter at any time, so it can preset a counter close to its limit and be told when the counter wraps.

A counter that steps past its largest value wraps to zero and sets its bit in an overflow status register. Status bits are cleared through a separate write-one-to-clear register. A mask register with inverted sense (a 1 blocks the bit) decides which status bits may raise the single level interrupt output.

The register bus has separate write and read ports. A write happens on the clock edge at which `wr_en` is high. A read captures the addressed register on the edge at which `rd_en` is high and presents it on `rd_data` from then on. The bus has no stall, and every access completes in one cycle. Event pulses are taken as they arrive and have no back-pressure, because a counter can always absorb one event per cycle.

Top module: `evc_bank`

## Requirements
- R1: After reset every counter reads 0, the control register (0x1E00) reads 0, the enable register (0x1E04) reads 0, the mask register (0x0804) reads 0xFFFF, the status register (0x0808) reads 0, every select register reads 0xFFFFFFFF, and `irq` is 0.
- R2: `rd_data` shows the register addressed by `rd_addr` one clock after the edge that samples `rd_en`, and holds that value until the next read. Registers 32 bits wide or narrower appear in `rd_data[31:0]` with the upper bits zero, and take their write value from `wr_data[31:0]`. An unmapped address reads as 0.
- R3: Counter n sits at byte address 0x1F00 + 8*n. A write there loads `wr_data[47:0]` into the counter. A read returns the counter value with bits 63:48 zero. Writes to bits 63:48 are ignored, and a write to one counter leaves the other counters unchanged.
- R4: The event code of counter n is held in byte n%4 (bits 8*(n%4)+7 down to 8*(n%4)) of the select register at 0x1E80 + 4*(n/4). All four select registers are read/write.
- R5: A counter adds exactly one on each clock in which `events[code]` is 1, bit 0 of the control register is 1 and bit n of the enable register is 1.
- R6: A counter with code 0xFF, or with any code of 64 or above, never advances.
- R7: While control bit 0 is 0, or while the counter's own enable bit is 0, the counter holds its value.
- R8: A counter that holds 0xFFFF_FFFF_FFFF and advances becomes 0. Status bit n (0x0808) sets on that same clock edge.
- R9: Writing 1 to bit n of the clear register (0x080C) clears status bit n, and writing 0 leaves it unchanged. If an overflow and a clear of the same bit fall in one cycle, the bit ends up set. Writes to 0x0808 are ignored.
- R10: `irq` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R11: The register at 0x1CF0 reads the `VERSION_ID` parameter, and writes to it are ignored.
- R12: When a counter write and an increment of the same counter fall in one cycle, the written value wins and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 64 | Registered read data |
| events | input | 64 | Event pulse vector, indexed by event code |
| irq | output | 1 | Level interrupt |

## Verification
An overflow cannot be reached by counting from zero, since that would take 2^48 events. The bench therefore preloads a counter a few steps below its limit and then pulses its event a fixed number of cycles. The hardest case is an overflow and a software clear of the same status bit landing on one clock edge. The bench gets there by driving the event line and the clear-register write on the same falling edge while the counter sits at its maximum value. A counter write that collides with an increment is set up the same way, with the event held high during the write.

// File: rtl/evc_pkg.sv
package evc_pkg;
  // byte addresses of the register map
  localparam int OFF_MASK = 'h0804;
  localparam int OFF_STS  = 'h0808;
  localparam int OFF_CLR  = 'h080C;
  localparam int OFF_VER  = 'h1CF0;
  localparam int OFF_CTRL = 'h1E00;
  localparam int OFF_ENA  = 'h1E04;
  localparam int OFF_SEL  = 'h1E80;
  localparam int OFF_CNT  = 'h1F00;
  localparam int SEL_STRIDE = 4;
  localparam int CNT_STRIDE = 8;
  localparam int SEL_REG_W  = 32;
endpackage

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int CNT_W  = 48,
  parameter int CODE_W = 8,
  parameter int EVT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  input  logic [EVT_W-1:0]  events,
  input  logic              ld,
  input  logic [CNT_W-1:0]  ld_val,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf
);
  localparam int IDX_W = $clog2(EVT_W);

  logic hit;

  // codes beyond the event vector (including the idle code) match nothing
  always_comb begin
    hit = 1'b0;
    if (run && (32'(code) < EVT_W))
      hit = events[code[IDX_W-1:0]];
  end

  assign ovf = hit && !ld && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (ld)
      cnt <= ld_val;
    else if (hit)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/evc_irq.sv
module evc_irq #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ovf,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] sts,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts  <= '0;
      mask <= '1;
    end else begin
      sts <= (sts & ~clr_eff) | ovf;   // hardware set beats software clear
      if (mask_we)
        mask <= mask_wdata;
    end
  end

  assign irq = |(sts & ~mask);
endmodule

// File: rtl/evc_bank.sv
module evc_bank #(
  parameter int          NUM_CNT    = 16,
  parameter int          CNT_W      = 48,
  parameter int          EVT_W      = 64,
  parameter int          CODE_W     = 8,
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 64,
  parameter logic [31:0] VERSION_ID = 32'h0005_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [EVT_W-1:0]  events,
  output logic              irq
);
  import evc_pkg::*;

  localparam int PER_SEL = SEL_REG_W / CODE_W;
  localparam int NUM_SEL = NUM_CNT / PER_SEL;

  logic                              glb_en_q;
  logic [NUM_CNT-1:0]                ena_q;
  logic [NUM_CNT-1:0][CODE_W-1:0]    code_q;
  logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_q;
  logic [NUM_CNT-1:0]                ovf;
  logic [NUM_CNT-1:0]                sts_q;
  logic [NUM_CNT-1:0]                mask_q;
  logic [DATA_W-1:0]                 rd_mux;
  logic                              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

  // control, enable and select registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en_q <= 1'b0;
      ena_q    <= '0;
      code_q   <= '1;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(OFF_CTRL)) glb_en_q <= wr_data[0];
      if (wr_addr == ADDR_W'(OFF_ENA))  ena_q    <= wr_data[NUM_CNT-1:0];
      for (int j = 0; j < NUM_SEL; j++)
        if (wr_addr == ADDR_W'(OFF_SEL + SEL_STRIDE*j))
          for (int k = 0; k < PER_SEL; k++)
            code_q[j*PER_SEL+k] <= wr_data[k*CODE_W +: CODE_W];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    evc_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W), .EVT_W(EVT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (glb_en_q && ena_q[i]),
      .code   (code_q[i]),
      .events (events),
      .ld     (wr_en && (wr_addr == ADDR_W'(OFF_CNT + CNT_STRIDE*i))),
      .ld_val (wr_data[CNT_W-1:0]),
      .cnt    (cnt_q[i]),
      .ovf    (ovf[i])
    );
  end

  evc_irq #(.N(NUM_CNT)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf        (ovf),
    .clr_we     (wr_en && (wr_addr == ADDR_W'(OFF_CLR))),
    .clr_bits   (wr_data[NUM_CNT-1:0]),
    .mask_we    (wr_en && (wr_addr == ADDR_W'(OFF_MASK))),
    .mask_wdata (wr_data[NUM_CNT-1:0]),
    .sts        (sts_q),
    .mask       (mask_q),
    .irq        (irq)
  );

  // read decode
  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(OFF_CTRL)) rd_mux = DATA_W'(glb_en_q);
    if (rd_addr == ADDR_W'(OFF_ENA))  rd_mux = DATA_W'(ena_q);
    if (rd_addr == ADDR_W'(OFF_MASK)) rd_mux = DATA_W'(mask_q);
    if (rd_addr == ADDR_W'(OFF_STS))  rd_mux = DATA_W'(sts_q);
    if (rd_addr == ADDR_W'(OFF_VER))  rd_mux = DATA_W'(VERSION_ID);
    for (int j = 0; j < NUM_SEL; j++)
      if (rd_addr == ADDR_W'(OFF_SEL + SEL_STRIDE*j))
        rd_mux = DATA_W'(code_q[j*PER_SEL +: PER_SEL]);
    for (int i = 0; i < NUM_CNT; i++)
      if (rd_addr == ADDR_W'(OFF_CNT + CNT_STRIDE*i))
        rd_mux = DATA_W'(cnt_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_mux;
  end
endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk #(
  parameter int          NUM_CNT    = 16,
  parameter int          CNT_W      = 48,
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 64,
  parameter logic [31:0] VERSION_ID = 32'h0005_0100
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [DATA_W-1:0]             wr_data,
  input logic                          rd_en,
  input logic [ADDR_W-1:0]             rd_addr,
  input logic [DATA_W-1:0]             rd_data,
  input logic                          irq,
  input logic                          glb_en,
  input logic [NUM_CNT-1:0]            sts,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
  import evc_pkg::*;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq);

  // R11
  version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr == ADDR_W'(OFF_VER) |=> rd_data == DATA_W'(VERSION_ID));

  // R3
  cnt_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr >= ADDR_W'(OFF_CNT) && rd_addr < ADDR_W'(OFF_CNT + CNT_STRIDE*NUM_CNT)
    |=> rd_data[DATA_W-1:CNT_W] == '0);

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en && !wr_en |=> $stable(cnt));

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_bit
    // R8
    wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[i]) |-> cnt[i] == '0);
    // R9
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[i]) |-> $past(wr_en && wr_addr == ADDR_W'(OFF_CLR) && wr_data[i]));
  end
endmodule

bind evc_bank evc_bank_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION_ID(VERSION_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
  .glb_en(glb_en_q), .sts(sts_q), .cnt(cnt_q)
);

// File: tb/tb_evc_bank.sv
`timescale 1ns/1ps
module tb_evc_bank;
  localparam logic [31:0] VER = 32'h0005_0100;
  localparam logic [15:0] A_MASK = 16'h0804, A_STS = 16'h0808, A_CLR = 16'h080C;
  localparam logic [15:0] A_VER = 16'h1CF0, A_CTRL = 16'h1E00, A_ENA = 16'h1E04;
  localparam logic [15:0] A_SEL = 16'h1E80, A_CNT = 16'h1F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [63:0] rd_data;
  logic [63:0] events = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evc_bank #(.VERSION_ID(VER)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .events(events), .irq(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [15:0] a, logic [63:0] exp);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse(logic [63:0] v, int n);
    @(negedge clk);
    events = v;
    repeat (n) @(negedge clk);
    events = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", A_CTRL, 64'h0);
    rd_chk("R1 enable", A_ENA, 64'h0);
    rd_chk("R1 mask", A_MASK, 64'hFFFF);
    rd_chk("R1 status", A_STS, 64'h0);
    rd_chk("R1 select", A_SEL + 16'd12, 64'hFFFF_FFFF);
    rd_chk("R1 counter", A_CNT + 16'd40, 64'h0);
    chk("R1 irq", {63'b0, irq}, 64'h0);
  endtask

  task automatic t_version();
    rd_chk("R11 version", A_VER, {32'b0, VER});
    wr(A_VER, 64'h1234);
    rd_chk("R11 version after write", A_VER, {32'b0, VER});
    rd_chk("R2 unmapped", 16'h0100, 64'h0);
  endtask

  task automatic t_counter_rw();
    wr(A_CNT + 16'd24, 64'hABCD_1234_5678_9ABC);
    wr(A_CNT + 16'd32, 64'h77);
    rd_chk("R3 counter load", A_CNT + 16'd24, 64'h0000_1234_5678_9ABC);
    rd_chk("R3 neighbour", A_CNT + 16'd32, 64'h77);
    wr(A_CNT + 16'd32, 64'h0);
    wr(A_CNT + 16'd24, 64'h0);
  endtask

  task automatic t_select_count();
    wr(A_SEL + 16'd4, 64'hFFFF_FFFF_0C0B_0A09);
    rd_chk("R4 select readback", A_SEL + 16'd4, 64'h0C0B_0A09);
    wr(A_CTRL, 64'h1);
    wr(A_ENA, 64'h00F0);
    pulse(64'h1 << 10, 5);
    rd_chk("R5 counter5 counts", A_CNT + 16'd40, 64'd5);
    rd_chk("R4 counter4 other code", A_CNT + 16'd32, 64'd0);
    rd_chk("R4 counter6 other code", A_CNT + 16'd48, 64'd0);
  endtask

  task automatic t_gating();
    wr(A_CTRL, 64'h0);
    pulse(64'h1 << 10, 3);
    rd_chk("R7 global off", A_CNT + 16'd40, 64'd5);
    wr(A_CTRL, 64'h1);
    wr(A_ENA, 64'h00D0);
    pulse(64'h1 << 10, 3);
    rd_chk("R7 own enable off", A_CNT + 16'd40, 64'd5);
  endtask

  task automatic t_codes();
    wr(A_SEL, 64'hFF3F_40FF);
    wr(A_ENA, 64'h0007);
    pulse('1, 4);
    rd_chk("R6 idle code", A_CNT, 64'd0);
    rd_chk("R6 code 0x40", A_CNT + 16'd8, 64'd0);
    rd_chk("R5 code 0x3F", A_CNT + 16'd16, 64'd4);
  endtask

  task automatic t_overflow();
    wr(A_CNT + 16'd16, 64'hFFFF_FFFF_FFFE);
    pulse(64'h1 << 63, 3);
    rd_chk("R8 wrap value", A_CNT + 16'd16, 64'd1);
    rd_chk("R8 status set", A_STS, 64'h4);
    chk("R10 masked irq", {63'b0, irq}, 64'h0);
    wr(A_MASK, 64'hFFFB);
    chk("R10 unmasked irq", {63'b0, irq}, 64'h1);
  endtask

  task automatic t_clear();
    wr(A_CLR, 64'h0);
    rd_chk("R9 write zero", A_STS, 64'h4);
    wr(A_STS, 64'h0);
    rd_chk("R9 status not writable", A_STS, 64'h4);
    wr(A_CLR, 64'h4);
    rd_chk("R9 cleared", A_STS, 64'h0);
    chk("R10 irq low", {63'b0, irq}, 64'h0);
    wr(A_CNT + 16'd16, 64'hFFFF_FFFF_FFFF);
    @(negedge clk);
    events = 64'h1 << 63; wr_en = 1'b1; wr_addr = A_CLR; wr_data = 64'h4;
    @(negedge clk);
    events = '0; wr_en = 1'b0;
    rd_chk("R9 set wins", A_STS, 64'h4);
    chk("R10 irq after collision", {63'b0, irq}, 64'h1);
  endtask

  task automatic t_write_wins();
    wr(A_CLR, 64'h4);
    wr(A_CNT + 16'd16, 64'hFFFF_FFFF_FFFF);
    @(negedge clk);
    events = 64'h1 << 63; wr_en = 1'b1; wr_addr = A_CNT + 16'd16; wr_data = 64'd100;
    @(negedge clk);
    events = '0; wr_en = 1'b0;
    rd_chk("R12 write beats increment", A_CNT + 16'd16, 64'd100);
    rd_chk("R12 no overflow", A_STS, 64'h0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_version();
    t_counter_rw();
    t_select_count();
    t_gating();
    t_codes();
    t_overflow();
    t_clear();
    t_write_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule